// File: doc/BRIEF.md
# Interrupt Priority and Halt Dispatcher

This block decides which pending event the processor should take next. It watches a set of level-sensitive maskable request lines, each tied to a fixed priority level, and a small set of nonmaskable halt sources. It compares them with the current processor priority level and produces a single dispatch command. A maskable command carries the new priority level and a vector offset, read from a per-line table. A halt command carries a halt code and the maximum priority level. The command ignores the current priority level.

The command is registered and held until the consumer acknowledges it. In the first cycle of every command, the block pulses save strobes for the program counter and the status longword. It also pulses a strobe for the memory-mapping-enable bit, but only for halts. After an acknowledge the block returns to idle. It then evaluates any request that is still asserted, so a request that stays high is dispatched again.

Top module: `irq_halt_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `disp_valid`, `save_pc`, `save_psl` and `save_mapen` are 0.
- R2: Maskable line i has priority level LVL_BASE+i (default LVL_BASE = 0x16, so line 4 is level 0x1A and line 7 is level 0x1D). It is eligible only when that level is strictly greater than `cur_ipl`. A request at a level equal to or below `cur_ipl` produces no dispatch.
- R3: Among eligible maskable lines, the highest level wins. The command has `disp_is_halt`=0 and `disp_ipl` = the winning level. `disp_vec` = table entry i, which is `vec_tbl[i*VEC_W +: VEC_W]`.
- R4: Any asserted halt source is dispatched whatever the value of `cur_ipl`, including the maximum of 0x1F. The command has `disp_is_halt`=1, `disp_ipl`=0x1F, `disp_vec`=0, and `disp_hcode` = the source's code, `halt_code_tbl[k*HC_W +: HC_W]`.
- R5: A halt source wins over every maskable request seen in the same cycle. Among several halt sources, the lowest index wins.
- R6: When no command is pending, requests seen at a clock edge appear as a command (`disp_valid`=1) right after that edge. While `disp_valid`=1 and `disp_ack`=0, every command field is held, whatever the request inputs do.
- R7: `save_pc` and `save_psl` are 1 only in the first cycle of each command. `save_mapen` is 1 in that cycle for halt commands only. All three are 0 otherwise.
- R8: `disp_valid` falls in the cycle after `disp_ack` is seen high with a command pending. Requests still asserted are evaluated again and yield a new command one cycle later.
- R9: A maskable command carries `disp_hcode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_LVL | Level-sensitive maskable requests, line i at level LVL_BASE+i |
| vec_tbl | input | NUM_LVL*VEC_W | Vector offset per line, entry i at bits i*VEC_W |
| halt_req | input | NUM_HALT | Nonmaskable halt sources, lowest index first |
| halt_code_tbl | input | NUM_HALT*HC_W | Halt code per source, entry k at bits k*HC_W |
| cur_ipl | input | IPL_W | Current processor priority level |
| disp_ack | input | 1 | Consumer accepts the pending command |
| disp_valid | output | 1 | A command is pending |
| disp_is_halt | output | 1 | Pending command is a halt |
| disp_ipl | output | IPL_W | New priority level for the command |
| disp_vec | output | VEC_W | Vector offset (0 for halts) |
| disp_hcode | output | HC_W | Halt code (0 for maskable) |
| save_pc | output | 1 | Save program counter strobe |
| save_psl | output | 1 | Save status longword strobe |
| save_mapen | output | 1 | Save memory-mapping-enable strobe (halts only) |

## Verification
Suppose the controller sits in a wrong state, such as holding past an acknowledge or failing to leave idle. This shows on `disp_valid` within one cycle of the acknowledge or of the request. A corrupted captured field shows as a change in `disp_ipl`, `disp_vec` or `disp_hcode` during a held cycle. A strobe state entered at the wrong time shows as a `save_pc` pulse outside the first cycle of a command. An error in the selector shows the cycle after the request: a level at or below `cur_ipl` gets dispatched, the wrong line or halt source wins, or a halt is blocked.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   // Dispatch controller state: idle, first cycle of a command, held command
   typedef enum logic [1:0] {
      DS_IDLE  = 2'd0,
      DS_FRESH = 2'd1,
      DS_HOLD  = 2'd2
   } disp_state_e;
endpackage

// File: rtl/irqd_mask_sel.sv
module irqd_mask_sel #(
   parameter int NUM_LVL  = 8,
   parameter int IPL_W    = 5,
   parameter int VEC_W    = 9,
   parameter int LVL_BASE = 22
) (
   input  logic [NUM_LVL-1:0]       req,
   input  logic [NUM_LVL*VEC_W-1:0] vec_tbl,
   input  logic [IPL_W-1:0]         cur_ipl,
   output logic                     hit,
   output logic [IPL_W-1:0]         lvl,
   output logic [VEC_W-1:0]         vec
);
   logic [NUM_LVL-1:0] elig;

   // Per-line masking against the current level
   for (genvar g = 0; g < NUM_LVL; g++) begin : g_elig
      localparam logic [IPL_W-1:0] LINE_LVL = IPL_W'(LVL_BASE + g);
      assign elig[g] = req[g] && (LINE_LVL > cur_ipl);
   end

   // Levels rise with the index: the last eligible line scanned wins
   always_comb begin
      hit = 1'b0;
      lvl = '0;
      vec = '0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (elig[i]) begin
            hit = 1'b1;
            lvl = IPL_W'(LVL_BASE + i);
            vec = vec_tbl[i*VEC_W +: VEC_W];
         end
      end
   end
endmodule

// File: rtl/irqd_halt_sel.sv
module irqd_halt_sel #(
   parameter int NUM_HALT = 3,
   parameter int HC_W     = 6
) (
   input  logic [NUM_HALT-1:0]      req,
   input  logic [NUM_HALT*HC_W-1:0] code_tbl,
   output logic                     hit,
   output logic [HC_W-1:0]          code
);
   // Scan from the top down so the lowest index is assigned last and wins
   always_comb begin
      hit  = 1'b0;
      code = '0;
      for (int i = NUM_HALT - 1; i >= 0; i--) begin
         if (req[i]) begin
            hit  = 1'b1;
            code = code_tbl[i*HC_W +: HC_W];
         end
      end
   end
endmodule

// File: rtl/irqd_disp_ctl.sv
module irqd_disp_ctl
   import irqd_pkg::*;
#(
   parameter int IPL_W = 5,
   parameter int VEC_W = 9,
   parameter int HC_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cand,
   input  logic             cand_halt,
   input  logic [IPL_W-1:0] cand_ipl,
   input  logic [VEC_W-1:0] cand_vec,
   input  logic [HC_W-1:0]  cand_code,
   input  logic             ack,
   output logic             valid,
   output logic             fresh,
   output logic             is_halt,
   output logic [IPL_W-1:0] ipl,
   output logic [VEC_W-1:0] vec,
   output logic [HC_W-1:0]  code
);
   disp_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DS_IDLE;
         is_halt <= 1'b0;
         ipl     <= '0;
         vec     <= '0;
         code    <= '0;
      end else begin
         case (state_q)
            DS_IDLE: begin
               if (cand) begin
                  state_q <= DS_FRESH;
                  is_halt <= cand_halt;
                  ipl     <= cand_ipl;
                  vec     <= cand_vec;
                  code    <= cand_code;
               end
            end
            DS_FRESH: state_q <= ack ? DS_IDLE : DS_HOLD;
            DS_HOLD:  if (ack) state_q <= DS_IDLE;
            default:  state_q <= DS_IDLE;
         endcase
      end
   end

   assign valid = (state_q != DS_IDLE);
   assign fresh = (state_q == DS_FRESH);
endmodule

// File: rtl/irq_halt_dispatch.sv
module irq_halt_dispatch #(
   parameter int NUM_LVL  = 8,
   parameter int NUM_HALT = 3,
   parameter int IPL_W    = 5,
   parameter int VEC_W    = 9,
   parameter int HC_W     = 6,
   parameter int LVL_BASE = 22
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_LVL-1:0]        irq_req,
   input  logic [NUM_LVL*VEC_W-1:0]  vec_tbl,
   input  logic [NUM_HALT-1:0]       halt_req,
   input  logic [NUM_HALT*HC_W-1:0]  halt_code_tbl,
   input  logic [IPL_W-1:0]          cur_ipl,
   input  logic                      disp_ack,
   output logic                      disp_valid,
   output logic                      disp_is_halt,
   output logic [IPL_W-1:0]          disp_ipl,
   output logic [VEC_W-1:0]          disp_vec,
   output logic [HC_W-1:0]           disp_hcode,
   output logic                      save_pc,
   output logic                      save_psl,
   output logic                      save_mapen
);
   localparam int                 NUM_IPL = 1 << IPL_W;
   localparam logic [IPL_W-1:0]   IPL_TOP = IPL_W'(NUM_IPL - 1);

   // Elaboration-time parameter checks
   if (NUM_LVL < 1) begin : g_bad_lvl
      $error("NUM_LVL must be at least 1");
   end
   if (NUM_HALT < 1) begin : g_bad_halt
      $error("NUM_HALT must be at least 1");
   end
   if (LVL_BASE < 1 || LVL_BASE + NUM_LVL > NUM_IPL) begin : g_bad_base
      $error("maskable levels must lie in 1 .. 2**IPL_W-1");
   end
   if (VEC_W < 1 || HC_W < 1) begin : g_bad_w
      $error("VEC_W and HC_W must be at least 1");
   end

   logic             m_hit, h_hit;
   logic [IPL_W-1:0] m_lvl;
   logic [VEC_W-1:0] m_vec;
   logic [HC_W-1:0]  h_code;

   irqd_mask_sel #(
      .NUM_LVL (NUM_LVL),
      .IPL_W   (IPL_W),
      .VEC_W   (VEC_W),
      .LVL_BASE(LVL_BASE)
   ) mask_sel_i (
      .req    (irq_req),
      .vec_tbl(vec_tbl),
      .cur_ipl(cur_ipl),
      .hit    (m_hit),
      .lvl    (m_lvl),
      .vec    (m_vec)
   );

   irqd_halt_sel #(
      .NUM_HALT(NUM_HALT),
      .HC_W    (HC_W)
   ) halt_sel_i (
      .req     (halt_req),
      .code_tbl(halt_code_tbl),
      .hit     (h_hit),
      .code    (h_code)
   );

   // Halt overrides any maskable candidate
   logic             c_valid;
   logic [IPL_W-1:0] c_ipl;
   logic [VEC_W-1:0] c_vec;
   logic [HC_W-1:0]  c_code;

   always_comb begin
      c_valid = h_hit | m_hit;
      if (h_hit) begin
         c_ipl  = IPL_TOP;
         c_vec  = '0;
         c_code = h_code;
      end else begin
         c_ipl  = m_lvl;
         c_vec  = m_vec;
         c_code = '0;
      end
   end

   logic fresh;

   irqd_disp_ctl #(
      .IPL_W(IPL_W),
      .VEC_W(VEC_W),
      .HC_W (HC_W)
   ) ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand     (c_valid),
      .cand_halt(h_hit),
      .cand_ipl (c_ipl),
      .cand_vec (c_vec),
      .cand_code(c_code),
      .ack      (disp_ack),
      .valid    (disp_valid),
      .fresh    (fresh),
      .is_halt  (disp_is_halt),
      .ipl      (disp_ipl),
      .vec      (disp_vec),
      .code     (disp_hcode)
   );

   assign save_pc    = fresh;
   assign save_psl   = fresh;
   assign save_mapen = fresh & disp_is_halt;
endmodule

// File: rtl/irq_halt_dispatch_chk.sv
module irq_halt_dispatch_chk #(
   parameter int NUM_HALT = 3,
   parameter int IPL_W    = 5,
   parameter int HC_W     = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_HALT-1:0] halt_req,
   input logic [IPL_W-1:0]    cur_ipl,
   input logic                disp_ack,
   input logic                disp_valid,
   input logic                disp_is_halt,
   input logic [IPL_W-1:0]    disp_ipl,
   input logic [HC_W-1:0]     disp_hcode,
   input logic                save_pc,
   input logic                save_mapen
);
   // R2
   level_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(disp_valid) && !disp_is_halt) |-> (disp_ipl > $past(cur_ipl)));

   // R4
   halt_top_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_is_halt) |-> (disp_ipl == {IPL_W{1'b1}}));

   // R5
   halt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_valid) |-> (disp_is_halt == $past(|halt_req)));

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ack) |=> (disp_valid && $stable(disp_ipl)
                                     && $stable(disp_hcode) && $stable(disp_is_halt)));

   // R7
   strobe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_pc |-> (disp_valid && !$past(disp_valid)));

   // R7
   mapen_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_mapen |-> (save_pc && disp_is_halt));

   // R8
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ack) |=> !disp_valid);

   // R9
   mask_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_is_halt) |-> (disp_hcode == '0));
endmodule

bind irq_halt_dispatch irq_halt_dispatch_chk #(
   .NUM_HALT(NUM_HALT),
   .IPL_W   (IPL_W),
   .HC_W    (HC_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .halt_req    (halt_req),
   .cur_ipl     (cur_ipl),
   .disp_ack    (disp_ack),
   .disp_valid  (disp_valid),
   .disp_is_halt(disp_is_halt),
   .disp_ipl    (disp_ipl),
   .disp_hcode  (disp_hcode),
   .save_pc     (save_pc),
   .save_mapen  (save_mapen)
);

// File: tb/irq_halt_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_halt_dispatch_tb_top;
   localparam int NL = 8;
   localparam int NH = 3;
   localparam int IW = 5;
   localparam int VW = 9;
   localparam int CW = 6;
   localparam int LB = 22;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL-1:0]   irq_req = '0;
   logic [NL*VW-1:0] vec_tbl;
   logic [NH-1:0]   halt_req = '0;
   logic [NH*CW-1:0] halt_code_tbl;
   logic [IW-1:0]   cur_ipl = '0;
   logic            disp_ack = 1'b0;
   logic            disp_valid, disp_is_halt, save_pc, save_psl, save_mapen;
   logic [IW-1:0]   disp_ipl;
   logic [VW-1:0]   disp_vec;
   logic [CW-1:0]   disp_hcode;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irq_halt_dispatch dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_tbl(vec_tbl),
      .halt_req(halt_req), .halt_code_tbl(halt_code_tbl), .cur_ipl(cur_ipl),
      .disp_ack(disp_ack), .disp_valid(disp_valid), .disp_is_halt(disp_is_halt),
      .disp_ipl(disp_ipl), .disp_vec(disp_vec), .disp_hcode(disp_hcode),
      .save_pc(save_pc), .save_psl(save_psl), .save_mapen(save_mapen)
   );

   function automatic logic [VW-1:0] vec_of(input int i);
      return VW'(32'h44 + 4 * i);   // line 4 -> 0x54, line 7 -> 0x60
   endfunction

   function automatic logic [CW-1:0] code_of(input int k);
      case (k)
         0:       return CW'(2);   // external halt
         1:       return CW'(6);
         default: return CW'(9);
      endcase
   endfunction

   // Expected command from the requirements
   function automatic void model(input logic [NL-1:0] rq, input logic [NH-1:0] hr,
                                 input logic [IW-1:0] ipl, output bit v, output bit h,
                                 output logic [IW-1:0] el, output logic [VW-1:0] ev,
                                 output logic [CW-1:0] ec);
      v = 0; h = 0; el = '0; ev = '0; ec = '0;
      for (int k = NH - 1; k >= 0; k--)
         if (hr[k]) begin v = 1; h = 1; ec = code_of(k); end
      if (h) begin el = 5'h1F; return; end
      for (int i = 0; i < NL; i++)
         if (rq[i] && (LB + i > int'(ipl))) begin v = 1; el = IW'(LB + i); ev = vec_of(i); end
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Starts and ends at a negedge with no command pending
   task automatic trial(input logic [NL-1:0] rq, input logic [NH-1:0] hr,
                        input logic [IW-1:0] ipl, input bit reeval);
      bit v, h;
      logic [IW-1:0] el;
      logic [VW-1:0] ev;
      logic [CW-1:0] ec;
      model(rq, hr, ipl, v, h, el, ev, ec);
      irq_req = rq; halt_req = hr; cur_ipl = ipl; disp_ack = 1'b0;
      @(negedge clk);
      chk("R2 R6 dispatch taken", disp_valid, v);
      if (!v) begin
         chk("R7 no strobes when idle", {save_pc, save_psl, save_mapen}, 0);
         irq_req = '0; halt_req = '0;
         return;
      end
      chk("R5 halt flag", disp_is_halt, h);
      chk(h ? "R4 halt ipl" : "R3 level", disp_ipl, el);
      chk(h ? "R4 halt vec" : "R3 vector", disp_vec, ev);
      chk(h ? "R4 halt code" : "R9 zero code", disp_hcode, ec);
      chk("R7 first-cycle strobes", {save_pc, save_psl, save_mapen}, {1'b1, 1'b1, h});
      // change inputs while held
      irq_req = NL'($urandom); halt_req = NH'($urandom); cur_ipl = IW'($urandom);
      @(negedge clk);
      chk("R6 held valid", disp_valid, 1);
      chk("R6 held fields", {disp_is_halt, disp_ipl, disp_vec, disp_hcode}, {h, el, ev, ec});
      chk("R7 strobes after first", {save_pc, save_psl, save_mapen}, 0);
      irq_req = rq; halt_req = hr; cur_ipl = ipl; disp_ack = 1'b1;
      @(negedge clk);
      disp_ack = 1'b0;
      chk("R8 valid drop", disp_valid, 0);
      if (reeval) begin
         @(negedge clk);
         chk("R8 re-dispatch", disp_valid, 1);
         chk("R8 re-dispatch fields", {disp_is_halt, disp_ipl, disp_vec, disp_hcode}, {h, el, ev, ec});
         disp_ack = 1'b1;
         @(negedge clk);
         disp_ack = 1'b0;
         chk("R8 second drop", disp_valid, 0);
      end
      irq_req = '0; halt_req = '0;
   endtask

   initial begin
      for (int i = 0; i < NL; i++) vec_tbl[i*VW +: VW] = vec_of(i);
      for (int k = 0; k < NH; k++) halt_code_tbl[k*CW +: CW] = code_of(k);
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd1957);
      irq_req = 8'hFF; halt_req = 3'b111;
      repeat (3) @(negedge clk);
      chk("R1 in reset", {disp_valid, save_pc, save_psl, save_mapen}, 0);
      irq_req = '0; halt_req = '0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {disp_valid, save_pc, save_psl, save_mapen}, 0);

      // R2: equal level is masked, one above is taken
      trial(8'b0001_0000, 3'b000, 5'h1A, 0);
      trial(8'b0010_0000, 3'b000, 5'h1A, 0);
      // R3: highest level wins, vector of level 0x1D
      trial(8'b1001_0011, 3'b000, 5'h00, 0);
      trial(8'b0001_0000, 3'b000, 5'h19, 0);
      // R4: halt at maximum IPL
      trial(8'b1000_0000, 3'b001, 5'h1F, 0);
      // R5: lowest halt index wins
      trial(8'hFF, 3'b110, 5'h00, 0);
      // R8: re-evaluation of held requests
      trial(8'b0100_0000, 3'b000, 5'h10, 1);
      trial(8'h00, 3'b100, 5'h1F, 1);

      for (int n = 0; n < 300; n++) begin
         logic [NH-1:0] hr;
         hr = ($urandom_range(0, 3) == 0) ? NH'($urandom) : '0;
         trial(NL'($urandom), hr, IW'($urandom_range(16, 31)), ($urandom_range(0, 7) == 0));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule